// File: doc/BRIEF.md
# On-chip SRAM access filter with base-address register

This block guards a small on-chip SRAM. A single configuration register places the SRAM at a naturally aligned base address and sets its attributes: an enable for the processor path, an enable for a secondary path used by other bus masters, a write-protect bit, and five per-address-space inhibit bits. Every processor request carries an address, a read/write flag and a 3-bit address-space code. The block decides whether the request is an SRAM access, a dropped protected write, or an ordinary reference that must be handled elsewhere. That last case is signalled on a pass-through flag.

The secondary port addresses the SRAM by word index. It ignores the inhibit bits, the processor enable and write protection, and obeys only its own enable. Both ports share one array. When the processor's access is granted, it wins the cycle, and a backdoor request made in that cycle sees its ready signal held low. Reads return data one cycle after the access is granted. The array is never cleared by reset. Software usually loads the SRAM and then rewrites the register with the final protection and inhibit settings, which leaves the stored data untouched.

Top module: `sram_gate`

## Requirements
- R1: After a synchronous reset the register reads back as 0x0000_0002: base 0, processor enable (bit 0) clear, backdoor enable (bit 1) set, write-protect (bit 2) clear, inhibit bits (bits 7:3) clear. A register write takes effect on the next cycle, and the base field occupies address bits [31:SIZE_LOG2].
- R2: While the processor enable is clear, no processor request selects the SRAM, and every processor request raises the pass-through flag in the same cycle.
- R3: Right after reset, a backdoor request selects the SRAM in the cycle it is made, with ready high.
- R4: A processor request selects the SRAM only when its address bits above SIZE_LOG2 equal the base field. Addresses just below or just above the window raise the pass-through flag.
- R5: The address-space codes are 0 CPU-space/interrupt-acknowledge, 1 supervisor code, 2 supervisor data, 3 user code and 4 user data, and code k is inhibited by register bit 3+k. An inhibited request, or one with code 5, 6 or 7, does not select the SRAM, raises the pass-through flag, and leaves the contents unchanged.
- R6: The inhibit bits and the processor enable have no effect on backdoor accesses.
- R7: With write-protect set, a processor write inside the window does not select or write the SRAM and does not raise the pass-through flag. It raises the error flag for exactly the following cycle. Processor reads and backdoor writes are unaffected.
- R8: Rewriting the register after the SRAM has been loaded leaves the stored contents unchanged.
- R9: When the processor's access is granted and a backdoor request is present in the same cycle, the processor takes the array and backdoor ready is low. The backdoor access completes in the first cycle without a processor grant.
- R10: A granted read raises the port's read-valid flag in the next cycle, with the addressed word on the read-data output.
- R11: While the backdoor enable is clear, a backdoor request does not select the SRAM, produces no read-valid, and still sees ready high.
- R12: Reset does not alter the array: a word written before a reset reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | ADDR_W | Register write value |
| cfg_rdata | output | ADDR_W | Current register value |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_as | input | 3 | Processor address-space code |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_pass | output | 1 | Request is not an SRAM reference |
| cpu_wp_err | output | 1 | Protected write was dropped in the previous cycle |
| cpu_rvalid | output | 1 | Processor read data valid |
| bd_req | input | 1 | Backdoor request |
| bd_we | input | 1 | Backdoor write (1) or read (0) |
| bd_idx | input | SIZE_LOG2-log2(DATA_W/8) | Backdoor word index |
| bd_wdata | input | DATA_W | Backdoor write data |
| bd_ready | output | 1 | Backdoor request not stalled this cycle |
| bd_rvalid | output | 1 | Backdoor read data valid |
| mem_sel | output | 1 | SRAM selected this cycle |
| mem_we | output | 1 | SRAM written this cycle |
| rd_data | output | DATA_W | Read data from the array |

## Verification
The embedded properties assume that the address-space code is always driven with a defined value. They also assume that the drop-without-write property is only meaningful when no backdoor request is present, because in that cycle a granted backdoor write legitimately drives the write strobe. The stimulus drives every input on the falling edge, keeps the backdoor idle around protected processor writes, and holds a stalled backdoor request unchanged until ready returns. Array reads are made only at words that were written earlier in the run, so no check depends on the undefined power-up contents.

// File: rtl/sram_gate_pkg.sv
package sram_gate_pkg;

    // number of address-space classes that have their own inhibit bit
    localparam int NUM_SPACES = 5;
    localparam int AS_W       = 3;

    // address-space codes carried with each processor request
    localparam logic [AS_W-1:0] AS_CPU_SPACE = 3'd0;
    localparam logic [AS_W-1:0] AS_SUP_CODE  = 3'd1;
    localparam logic [AS_W-1:0] AS_SUP_DATA  = 3'd2;
    localparam logic [AS_W-1:0] AS_USR_CODE  = 3'd3;
    localparam logic [AS_W-1:0] AS_USR_DATA  = 3'd4;

    // attribute byte of the register, bit 0 first: enable, backdoor, protect, inhibits
    typedef struct packed {
        logic [NUM_SPACES-1:0] inhibit;
        logic                  wprot;
        logic                  bd_en;
        logic                  cpu_en;
    } cfg_attr_t;

    localparam int ATTR_W = $bits(cfg_attr_t);

    localparam cfg_attr_t ATTR_RESET = '{
        inhibit: '0,
        wprot:   1'b0,
        bd_en:   1'b1,
        cpu_en:  1'b0
    };

    // 1 when the given address-space code may not reach the SRAM
    function automatic logic space_blocked(logic [NUM_SPACES-1:0] inhibit,
                                           logic [AS_W-1:0]       code);
        logic blk;
        blk = 1'b1;
        for (int i = 0; i < NUM_SPACES; i++) begin
            if (code == i[AS_W-1:0]) blk = inhibit[i];
        end
        return blk;
    endfunction

endpackage

// File: rtl/sram_gate_cfg.sv
module sram_gate_cfg
    import sram_gate_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_LOG2 = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_wdata,
    output cfg_attr_t                   attr,
    output logic [ADDR_W-SIZE_LOG2-1:0] base,
    output logic [ADDR_W-1:0]           cfg_rdata
);

    localparam int BASE_W = ADDR_W - SIZE_LOG2;

    always_ff @(posedge clk) begin
        if (rst) begin
            attr <= ATTR_RESET;
            base <= '0;
        end else if (cfg_we) begin
            attr <= cfg_attr_t'(cfg_wdata[ATTR_W-1:0]);
            base <= cfg_wdata[ADDR_W-1:SIZE_LOG2];
        end
    end

    // bits between the attribute byte and the base field read as zero
    always_comb begin
        cfg_rdata                     = '0;
        cfg_rdata[ATTR_W-1:0]         = attr;
        cfg_rdata[ADDR_W-1:SIZE_LOG2] = base;
    end

    // unused middle write bits are simply dropped
    logic unused_mid;
    assign unused_mid = ^cfg_wdata[SIZE_LOG2-1:ATTR_W];

    AST_CFG_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (attr == ATTR_RESET && base == '0))
        else $error("register not at reset state");                 // R1

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we)) |-> $stable(cfg_rdata))
        else $error("register changed without a write");            // R8

    generate
        if (BASE_W < 1) begin : g_bad_size
            initial $error("SIZE_LOG2 leaves no base field");
        end
    endgenerate

endmodule

// File: rtl/sram_gate_filter.sv
module sram_gate_filter
    import sram_gate_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_LOG2 = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [AS_W-1:0]             cpu_as,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  cfg_attr_t                   attr,
    input  logic [ADDR_W-SIZE_LOG2-1:0] base,
    output logic                        cpu_gnt,
    output logic                        cpu_pass,
    output logic                        cpu_wp_drop
);

    logic in_window;
    logic space_ok;
    logic claim;

    assign in_window   = (cpu_addr[ADDR_W-1:SIZE_LOG2] == base);
    assign space_ok    = attr.cpu_en && !space_blocked(attr.inhibit, cpu_as);
    assign claim       = cpu_req && in_window && space_ok;

    // a claimed reference never leaves the SRAM path, even when dropped
    assign cpu_pass    = cpu_req && !claim;
    assign cpu_wp_drop = claim && cpu_we && attr.wprot;
    assign cpu_gnt     = claim && !cpu_wp_drop;

    logic unused_low;
    assign unused_low = ^cpu_addr[SIZE_LOG2-1:0];

    AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !attr.cpu_en) |-> (cpu_pass && !cpu_gnt))
        else $error("processor reached SRAM while disabled");       // R2

    AST_OUTSIDE_PASSES: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_addr[ADDR_W-1:SIZE_LOG2] != base) |-> (cpu_pass && !cpu_gnt))
        else $error("address outside window selected SRAM");        // R4

    AST_INHIBIT_PASSES: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && space_blocked(attr.inhibit, cpu_as)) |-> (cpu_pass && !cpu_wp_drop))
        else $error("inhibited address space reached SRAM");        // R5

    AST_EXCLUSIVE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_gnt, cpu_pass, cpu_wp_drop}))
        else $error("more than one outcome for one request");       // R7

endmodule

// File: rtl/sram_gate_arb.sv
module sram_gate_arb #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bd_en,
    input  logic              cpu_gnt,
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              bd_req,
    input  logic              bd_we,
    input  logic [IDX_W-1:0]  bd_idx,
    input  logic [DATA_W-1:0] bd_wdata,
    output logic              bd_gnt,
    output logic              bd_ready,
    output logic              mem_sel,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [DATA_W-1:0] mem_wdata
);

    // processor wins; a disabled backdoor request completes with no effect
    assign bd_gnt   = bd_req && bd_en && !cpu_gnt;
    assign bd_ready = !(bd_req && cpu_gnt);

    always_comb begin
        mem_sel   = cpu_gnt || bd_gnt;
        mem_we    = 1'b0;
        mem_idx   = bd_idx;
        mem_wdata = bd_wdata;
        if (cpu_gnt) begin
            mem_we    = cpu_we;
            mem_idx   = cpu_idx;
            mem_wdata = cpu_wdata;
        end else if (bd_gnt) begin
            mem_we    = bd_we;
        end
    end

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_gnt, bd_gnt}))
        else $error("both ports own the array");                    // R9

    AST_BD_STALLED: assert property (@(posedge clk) disable iff (rst)
        (bd_req && cpu_gnt) |-> (!bd_ready && mem_idx == cpu_idx))
        else $error("backdoor not stalled behind processor");       // R9

    AST_BD_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && bd_req) |-> (mem_sel && bd_ready))
        else $error("backdoor blocked right after reset");          // R3

    AST_BD_OFF: assert property (@(posedge clk) disable iff (rst)
        (bd_req && !bd_en && !cpu_gnt) |-> (!mem_sel && bd_ready))
        else $error("disabled backdoor reached SRAM");              // R11

endmodule

// File: rtl/sram_gate_array.sv
module sram_gate_array #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              sel,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    // contents deliberately have no reset
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (sel) begin
            if (we) store[idx] <= wdata;
            else    rdata      <= store[idx];
        end
    end

endmodule

// File: rtl/sram_gate.sv
module sram_gate
    import sram_gate_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SIZE_LOG2 = 10,
    localparam int OFF_W    = $clog2(DATA_W / 8),
    localparam int IDX_W    = SIZE_LOG2 - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [2:0]        cpu_as,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_pass,
    output logic              cpu_wp_err,
    output logic              cpu_rvalid,
    input  logic              bd_req,
    input  logic              bd_we,
    input  logic [IDX_W-1:0]  bd_idx,
    input  logic [DATA_W-1:0] bd_wdata,
    output logic              bd_ready,
    output logic              bd_rvalid,
    output logic              mem_sel,
    output logic              mem_we,
    output logic [DATA_W-1:0] rd_data
);

    localparam int BASE_W = ADDR_W - SIZE_LOG2;

    cfg_attr_t         attr;
    logic [BASE_W-1:0] base;
    logic              cpu_gnt;
    logic              cpu_wp_drop;
    logic              bd_gnt;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] mem_wdata;

    sram_gate_cfg #(
        .ADDR_W    (ADDR_W),
        .SIZE_LOG2 (SIZE_LOG2)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .attr      (attr),
        .base      (base),
        .cfg_rdata (cfg_rdata)
    );

    sram_gate_filter #(
        .ADDR_W    (ADDR_W),
        .SIZE_LOG2 (SIZE_LOG2)
    ) u_filter (
        .clk         (clk),
        .rst         (rst),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_as      (cpu_as),
        .cpu_addr    (cpu_addr),
        .attr        (attr),
        .base        (base),
        .cpu_gnt     (cpu_gnt),
        .cpu_pass    (cpu_pass),
        .cpu_wp_drop (cpu_wp_drop)
    );

    sram_gate_arb #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .bd_en     (attr.bd_en),
        .cpu_gnt   (cpu_gnt),
        .cpu_we    (cpu_we),
        .cpu_idx   (cpu_addr[SIZE_LOG2-1:OFF_W]),
        .cpu_wdata (cpu_wdata),
        .bd_req    (bd_req),
        .bd_we     (bd_we),
        .bd_idx    (bd_idx),
        .bd_wdata  (bd_wdata),
        .bd_gnt    (bd_gnt),
        .bd_ready  (bd_ready),
        .mem_sel   (mem_sel),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .mem_wdata (mem_wdata)
    );

    sram_gate_array #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_array (
        .clk   (clk),
        .sel   (mem_sel),
        .we    (mem_we),
        .idx   (mem_idx),
        .wdata (mem_wdata),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rvalid <= 1'b0;
            bd_rvalid  <= 1'b0;
            cpu_wp_err <= 1'b0;
        end else begin
            cpu_rvalid <= cpu_gnt && !cpu_we;
            bd_rvalid  <= bd_gnt && !bd_we;
            cpu_wp_err <= cpu_wp_drop;
        end
    end

    AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && attr.wprot && !bd_req) |-> !mem_we)
        else $error("protected processor write reached SRAM");      // R7

    AST_WP_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        cpu_wp_err |-> $past(cpu_req && cpu_we && attr.wprot))
        else $error("error pulse without protected write");         // R7

    AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cpu_rvalid || bd_rvalid) |-> $past(mem_sel && !mem_we))
        else $error("read valid without a read one cycle earlier"); // R10

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_rvalid, bd_rvalid}))
        else $error("both read-valid flags high");                  // R10

endmodule

// File: tb/sram_gate_bench.sv
module sram_gate_bench;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int SIZE_LOG2 = 10;
    localparam int IDX_W     = SIZE_LOG2 - 2;
    localparam int NVEC      = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_we;
    logic [ADDR_W-1:0] cfg_wdata;
    logic [ADDR_W-1:0] cfg_rdata;
    logic              cpu_req, cpu_we;
    logic [2:0]        cpu_as;
    logic [ADDR_W-1:0] cpu_addr;
    logic [DATA_W-1:0] cpu_wdata;
    logic              cpu_pass, cpu_wp_err, cpu_rvalid;
    logic              bd_req, bd_we;
    logic [IDX_W-1:0]  bd_idx;
    logic [DATA_W-1:0] bd_wdata;
    logic              bd_ready, bd_rvalid, mem_sel, mem_we;
    logic [DATA_W-1:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    sram_gate #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SIZE_LOG2 (SIZE_LOG2)
    ) u_sram_gate (
        .clk (clk), .rst (rst),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_as (cpu_as),
        .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
        .cpu_pass (cpu_pass), .cpu_wp_err (cpu_wp_err), .cpu_rvalid (cpu_rvalid),
        .bd_req (bd_req), .bd_we (bd_we), .bd_idx (bd_idx), .bd_wdata (bd_wdata),
        .bd_ready (bd_ready), .bd_rvalid (bd_rvalid),
        .mem_sel (mem_sel), .mem_we (mem_we), .rd_data (rd_data)
    );

    // processor vectors walked after the window is programmed
    typedef struct packed {
        logic        we;
        logic [2:0]  as;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        sel;
        logic        pass;
        logic        chk;
        logic [31:0] rd;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd2, 32'h2000_0010, 32'h1111_1111, 1'b1, 1'b0, 1'b0, 32'h0},          // R4
        '{1'b1, 3'd4, 32'h2000_0020, 32'h2222_2222, 1'b1, 1'b0, 1'b0, 32'h0},          // R4
        '{1'b1, 3'd3, 32'h2000_0030, 32'h3333_3333, 1'b0, 1'b1, 1'b0, 32'h0},          // R5
        '{1'b0, 3'd1, 32'h2000_03FC, 32'h0,         1'b1, 1'b0, 1'b0, 32'h0},          // R4
        '{1'b0, 3'd0, 32'h2000_0400, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0},          // R4
        '{1'b0, 3'd2, 32'h1FFF_FFFC, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0},          // R4
        '{1'b0, 3'd5, 32'h2000_0010, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0},          // R5
        '{1'b0, 3'd4, 32'h2000_0010, 32'h0,         1'b1, 1'b0, 1'b1, 32'h1111_1111},  // R10
        '{1'b0, 3'd4, 32'h2000_0020, 32'h0,         1'b1, 1'b0, 1'b1, 32'h2222_2222},  // R10
        '{1'b0, 3'd2, 32'h2000_0030, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0BAD_0030}   // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_we = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; bd_req = 1'b0; bd_we = 1'b0;
    endtask

    task automatic cfg_write(input logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle();
        repeat (3) cyc();
        rst = 1'b0;
    endtask

    task automatic bd_access(input logic we, input int idx, input logic [31:0] d);
        bd_req = 1'b1; bd_we = we; bd_idx = IDX_W'(idx); bd_wdata = d;
    endtask

    task automatic cpu_access(input logic we, input logic [2:0] as,
                              input logic [31:0] a, input logic [31:0] d);
        cpu_req = 1'b1; cpu_we = we; cpu_as = as; cpu_addr = a; cpu_wdata = d;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        cfg_wdata = '0; cpu_as = '0; cpu_addr = '0; cpu_wdata = '0;
        bd_idx = '0; bd_wdata = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state of the register
        check("R1 reset value", cfg_rdata, 32'h0000_0002);

        // R3 backdoor reaches SRAM immediately after reset
        bd_access(1'b1, 5, 32'hCAFE_0005);
        #1;
        check("R3 backdoor write select", {29'b0, mem_sel, mem_we, bd_ready}, 32'h7);
        cyc(); idle();

        // R12 a second reset leaves the written word in place
        do_reset();
        bd_access(1'b0, 5, 32'h0);
        cyc(); idle();
        check("R12 word survives reset", rd_data, 32'hCAFE_0005);
        check("R10 backdoor read valid", {31'b0, bd_rvalid}, 32'h1);

        // R2 processor disabled after reset
        cpu_access(1'b0, 3'd2, 32'h0000_0014, 32'h0);
        #1;
        check("R2 disabled processor", {30'b0, mem_sel, cpu_pass}, 32'h1);
        cyc(); idle();
        check("R2 no read valid", {31'b0, cpu_rvalid}, 32'h0);

        // seed word 12 so the inhibited write can be observed
        bd_access(1'b1, 12, 32'h0BAD_0030);
        cyc(); idle();

        // window at 0x2000_0000, enabled, user code (code 3, bit 6) inhibited
        cfg_write(32'h2000_0043);
        check("R1 register readback", cfg_rdata, 32'h2000_0043);

        for (int i = 0; i < NVEC; i++) begin
            cpu_access(VECS[i].we, VECS[i].as, VECS[i].addr, VECS[i].wdata);
            #1;
            check($sformatf("R4 R5 vector %0d select/pass/we", i),
                  {29'b0, mem_sel, cpu_pass, mem_we},
                  {29'b0, VECS[i].sel, VECS[i].pass, VECS[i].sel & VECS[i].we});
            cyc(); idle();
            check($sformatf("R10 vector %0d read valid", i), {31'b0, cpu_rvalid},
                  {31'b0, VECS[i].sel & ~VECS[i].we});
            if (VECS[i].chk) check($sformatf("R10 vector %0d data", i), rd_data, VECS[i].rd);
        end

        // R6 inhibits all set, processor disabled: backdoor still works
        cfg_write(32'h2000_00FA);
        bd_access(1'b0, 4, 32'h0);
        #1;
        check("R6 backdoor select", {30'b0, mem_sel, bd_ready}, 32'h3);
        cyc(); idle();
        check("R6 backdoor data", rd_data, 32'h1111_1111);

        // R7 write protect
        cfg_write(32'h2000_0007);
        check("R8 register rewrite", cfg_rdata, 32'h2000_0007);
        cpu_access(1'b1, 3'd2, 32'h2000_0010, 32'hDEAD_BEEF);
        #1;
        check("R7 protected write dropped", {29'b0, mem_sel, mem_we, cpu_pass}, 32'h0);
        cyc(); idle();
        check("R7 error pulse", {31'b0, cpu_wp_err}, 32'h1);
        cyc();
        check("R7 error pulse ends", {31'b0, cpu_wp_err}, 32'h0);
        cpu_access(1'b0, 3'd2, 32'h2000_0010, 32'h0);
        cyc(); idle();
        check("R8 contents kept after rewrite", rd_data, 32'h1111_1111);
        check("R7 protected read valid", {31'b0, cpu_rvalid}, 32'h1);
        bd_access(1'b1, 4, 32'h4444_4444);
        #1;
        check("R7 backdoor write under protect", {30'b0, mem_sel, mem_we}, 32'h3);
        cyc(); idle();
        cpu_access(1'b0, 3'd4, 32'h2000_0010, 32'h0);
        cyc(); idle();
        check("R7 backdoor data landed", rd_data, 32'h4444_4444);

        // R9 collision: processor read wins, backdoor write waits one cycle
        cpu_access(1'b0, 3'd2, 32'h2000_0020, 32'h0);
        bd_access(1'b1, 8, 32'h5555_5555);
        #1;
        check("R9 backdoor stalled", {29'b0, mem_sel, mem_we, bd_ready}, 32'h4);
        cyc();
        cpu_req = 1'b0;
        check("R10 processor read after collision", rd_data, 32'h2222_2222);
        #1;
        check("R9 backdoor proceeds", {29'b0, mem_sel, mem_we, bd_ready}, 32'h7);
        cyc(); idle();
        cpu_access(1'b0, 3'd2, 32'h2000_0020, 32'h0);
        cyc(); idle();
        check("R9 stalled write landed", rd_data, 32'h5555_5555);

        // R11 backdoor disabled
        cfg_write(32'h2000_0001);
        bd_access(1'b0, 4, 32'h0);
        #1;
        check("R11 disabled backdoor", {30'b0, mem_sel, bd_ready}, 32'h1);
        cyc(); idle();
        check("R11 no backdoor read valid", {31'b0, bd_rvalid}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule